// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped countdown watchdog. Software programs a reload value and a control word through a simple register port. While the block is enabled, a counter decrements once per selected tick. The tick is either every bus clock cycle or a pulse on an external 1 MHz tick input. Software keeps the timer alive by writing a fixed 32-bit key to the restart register. Any other value written there does nothing.

When the count runs out, the block reloads the counter and raises a one-cycle pulse on the interrupt output, on the reset-request output, or on both, as the control word permits. A further control bit picks the scope of the requested reset (SoC only or full chip). That bit is driven as a level beside the request.

Reads are combinational: `rdData` reflects the register at `addr` in the same cycle.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the reload register reads 0x03EF1480, the control register reads 0, the count (status) reads 0x03EF1480, and `irqOut`, `rstReqOut` and `rstScopeOut` are 0.
- R2: Byte offsets: 0x00 status (current count, read only), 0x04 reload value (read/write), 0x08 restart (always reads 0), 0x0C control (bits 5:0 read back as written, higher bits read 0). Any other offset reads 0, and writes to it have no effect.
- R3: A write to offset 0x08 whose full 32-bit data equals 0x00004755 loads the counter from the reload register at the next clock edge. A write of any other value to 0x08 leaves the count and the outputs as they would otherwise be.
- R4: A control write that sets bit 0 while bit 0 is currently clear loads the counter from the reload register. Decrementing starts with the first tick after that write.
- R5: While control bit 0 is 1, the count decrements by one on each tick. With control bit 4 = 0, every clock cycle is a tick. With bit 4 = 1, only cycles with `tickIn` high are ticks.
- R6: While control bit 0 is 0, the count holds its value (restart and enable loads excepted). A control write that clears bit 0 stops counting from the next cycle.
- R7: A tick that arrives while the count is 1 or 0 is a timeout. The counter reloads from the reload register. In the next cycle, `irqOut` pulses for one cycle if control bit 2 is 1, and `rstReqOut` pulses for one cycle if control bit 1 is 1.
- R8: `rstScopeOut` equals control bit 5 (0 = SoC-only reset, 1 = full-chip reset).
- R9: In a cycle where a restart-key write or an enable-setting control write coincides with a tick, the load wins and no timeout occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| tickIn | input | 1 | 1 MHz tick pulse, one clock wide |
| irqOut | output | 1 | Timeout interrupt pulse |
| rstReqOut | output | 1 | Timeout reset-request pulse |
| rstScopeOut | output | 1 | Reset scope: 0 SoC, 1 full chip |

## Verification
The bench builds the block with its default parameters: a 32-bit count, the 0x03EF1480 reset reload value and the 0x4755 key. The reset reload is far too large to expire in a short run. The bench therefore reprograms reloads of 0 to 20. This puts timeouts, the count-of-one and count-of-zero edges, and collisions between restart writes and ticks within a few cycles. Random mixes of tick source, enable toggling and near-miss keys are compared every cycle against a bench model of the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 6;

  localparam logic [ADDR_W-1:0] OFF_STATUS  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_RELOAD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_RESTART = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 5'h0C;

  // control bit positions
  localparam int CB_EN      = 0;
  localparam int CB_RST_EN  = 1;
  localparam int CB_IRQ_EN  = 2;
  localparam int CB_TICKSEL = 4;
  localparam int CB_SCOPE   = 5;

  typedef struct packed {
    logic load;     // reload from restart key or enable rising
    logic dec;      // ordinary decrement
    logic fire;     // timeout: reload and pulse
    logic fireIrq;  // pulse interrupt with this timeout
    logic fireRst;  // pulse reset request with this timeout
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480,
  parameter logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickIn,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [DATA_W-1:0] rdData,
  output wdtStrobes_t       stb,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [CTRL_W-1:0] ctrlBits
);
  logic wrReload, wrCtrl, wrKey, enRise, tickNow, nearEnd;

  assign wrReload = wrEn && (addr == OFF_RELOAD);
  assign wrCtrl   = wrEn && (addr == OFF_CTRL);
  assign wrKey    = wrEn && (addr == OFF_RESTART) && (wrData == RESTART_KEY);
  assign enRise   = wrCtrl && wrData[CB_EN] && !ctrlBits[CB_EN];

  assign tickNow  = ctrlBits[CB_TICKSEL] ? tickIn : 1'b1;
  assign nearEnd  = (cntVal <= CNT_W'(1));

  always_comb begin
    stb         = '0;
    stb.load    = wrKey || enRise;
    if (!stb.load && ctrlBits[CB_EN] && tickNow) begin
      stb.fire = nearEnd;
      stb.dec  = !nearEnd;
    end
    stb.fireIrq = stb.fire && ctrlBits[CB_IRQ_EN];
    stb.fireRst = stb.fire && ctrlBits[CB_RST_EN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= RELOAD_RST;
      ctrlBits  <= '0;
    end else begin
      if (wrReload) reloadVal <= wrData[CNT_W-1:0];
      if (wrCtrl)   ctrlBits  <= wrData[CTRL_W-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      OFF_STATUS: rdData = DATA_W'(cntVal);
      OFF_RELOAD: rdData = DATA_W'(reloadVal);
      OFF_CTRL:   rdData = DATA_W'(ctrlBits);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobes_t      stb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             irqPulse,
  output logic             rstPulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal   <= RELOAD_RST;
      irqPulse <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      if (stb.load || stb.fire) cntVal <= reloadVal;
      else if (stb.dec)         cntVal <= cntVal - CNT_W'(1);
      irqPulse <= stb.fireIrq;
      rstPulse <= stb.fireRst;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480,
  parameter logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickIn,
  output logic              irqOut,
  output logic              rstReqOut,
  output logic              rstScopeOut
);
  wdtStrobes_t       stb;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  reloadVal;
  logic [CTRL_W-1:0] ctrlBits;

  wdt_control #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST), .RESTART_KEY(RESTART_KEY)) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .tickIn(tickIn), .cntVal(cntVal), .rdData(rdData), .stb(stb),
    .reloadVal(reloadVal), .ctrlBits(ctrlBits)
  );

  wdt_datapath #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reloadVal(reloadVal),
    .cntVal(cntVal), .irqPulse(irqOut), .rstPulse(rstReqOut)
  );

  assign rstScopeOut = ctrlBits[CB_SCOPE];
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic              rstReqOut,
  input wdtStrobes_t       stb,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CTRL_W-1:0] ctrlBits
);
  assert_restart_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == OFF_RESTART) |-> (rdData == '0));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(ctrlBits[CB_IRQ_EN]) && $past(cntVal) <= CNT_W'(1)));

  assert_rst_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |-> ($past(ctrlBits[CB_RST_EN]) && $past(cntVal) <= CNT_W'(1)));

  assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBits[CB_EN] && !(wrEn && (addr == OFF_RESTART || addr == OFF_CTRL)))
      |=> $stable(cntVal));

  assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.dec) |-> (cntVal == $past(cntVal) - CNT_W'(1)));

  assert_load_excludes_fire_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (!irqOut && !rstReqOut));
endmodule

bind keyed_watchdog wdt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .rdData(rdData),
  .irqOut(irqOut), .rstReqOut(rstReqOut), .stb(stb), .cntVal(cntVal),
  .ctrlBits(ctrlBits)
);

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
  logic clk = 0, rstN = 0, wrEn = 0, tickIn = 0;
  logic [4:0] addr = 0;
  logic [31:0] wrData = 0, rdData;
  logic irqOut, rstReqOut, rstScopeOut;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  keyed_watchdog dut_i (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickIn(tickIn), .irqOut(irqOut),
    .rstReqOut(rstReqOut), .rstScopeOut(rstScopeOut));

  always #5 clk = ~clk;

  // bench model
  logic [31:0] mReload = 32'h03EF1480, mCnt = 32'h03EF1480;
  logic [5:0]  mCtrl = 0;
  logic        mIrq = 0, mRst = 0;

  function automatic logic [31:0] modelRead(logic [4:0] a);
    case (a)
      5'h00: return mCnt;
      5'h04: return mReload;
      5'h0C: return {26'b0, mCtrl};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(logic we, logic [4:0] a, logic [31:0] d, logic tk);
    logic ld, tick;
    ld = we && ((a == 5'h08 && d == 32'h4755) || (a == 5'h0C && d[0] && !mCtrl[0]));
    tick = mCtrl[4] ? tk : 1'b1;
    mIrq = 0; mRst = 0;
    if (ld) mCnt = mReload;
    else if (mCtrl[0] && tick) begin
      if (mCnt <= 1) begin
        mCnt = mReload; mIrq = mCtrl[2]; mRst = mCtrl[1];
      end else mCnt = mCnt - 1;
    end
    if (we && a == 5'h04) mReload = d;
    if (we && a == 5'h0C) mCtrl = d[5:0];
  endtask

  // one cycle: compare outputs, drive, compare read, clock
  task automatic cyc(logic we, logic [4:0] a, logic [31:0] d, logic tk);
    check("R7 irqOut", {31'b0, irqOut}, {31'b0, mIrq});
    check("R7 rstReqOut", {31'b0, rstReqOut}, {31'b0, mRst});
    check("R8 rstScopeOut", {31'b0, rstScopeOut}, {31'b0, mCtrl[5]});
    wrEn = we; addr = a; wrData = d; tickIn = tk;
    #1;
    check("R2 rdData", rdData, modelRead(a));
    @(posedge clk);
    modelStep(we, a, d, tk);
    @(negedge clk);
    wrEn = 0; tickIn = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 5'h00, 0, 0);
  endtask

  initial begin
    #2000000;
    $display("FAIL watchdog expired");
    nFails++;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    addr = 5'h04; #1; check("R1 reload", rdData, 32'h03EF1480);
    addr = 5'h0C; #1; check("R1 ctrl", rdData, 0);
    addr = 5'h00; #1; check("R1 status", rdData, 32'h03EF1480);
    check("R1 outputs", {29'b0, irqOut, rstReqOut, rstScopeOut}, 0);
    rstN = 1;
    @(negedge clk);
    // R2 reads incl. unmapped and restart
    cyc(0, 5'h08, 0, 0); cyc(0, 5'h18, 0, 0); cyc(0, 5'h10, 0, 0);
    cyc(1, 5'h14, 32'hFFFF_FFFF, 0); cyc(0, 5'h14, 0, 0);
    // R4 enable with small reload, R5 bus-clock ticks, R7 timeout with irq+rst
    cyc(1, 5'h04, 32'd5, 0);
    cyc(1, 5'h0C, 32'h27, 0);
    idle(14);
    // R3 near-miss key ignored, correct key reloads
    cyc(1, 5'h08, 32'h0001_4755, 0);
    cyc(1, 5'h08, 32'h4754, 0);
    cyc(1, 5'h08, 32'h4755, 0);
    idle(3);
    // R6 disable freezes count
    cyc(1, 5'h0C, 32'h06, 0);
    idle(4);
    // R5 external tick source, R9 key with tick
    cyc(1, 5'h0C, 32'h17, 0);
    for (int i = 0; i < 20; i++) cyc(0, 5'h00, 0, (i % 3) == 0);
    cyc(1, 5'h08, 32'h4755, 1);
    // R7 reload zero: timeout on every tick
    cyc(1, 5'h04, 32'd0, 0);
    idle(4);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      logic tk = ($urandom_range(0, 3) == 0);
      if (r < 8)       cyc(1, 5'h04, 32'($urandom_range(0, 20)), tk);
      else if (r < 14) cyc(1, 5'h0C, {26'b0, 6'($urandom)}, tk);
      else if (r < 20) cyc(1, 5'h08, ($urandom_range(0, 1) ? 32'h4755 : 32'h4755 ^ (32'h1 << $urandom_range(0, 31))), tk);
      else             cyc(0, 5'($urandom_range(0, 7) * 4), 0, tk);
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule